// File: doc/BRIEF.md
# Asynchronous Packet Receive Filter and Acknowledger

This block sits in the receive path of a serial-bus link layer. Every packet on the bus reaches every node, so each node has to decide which packets are its own. The deframer presents one parsed asynchronous header per cycle: destination ID, source ID, transaction code, transaction label and a CRC-good flag. The block compares the destination with the node's own ID and with the broadcast address. It drops packets meant for other nodes. For packets it accepts, it returns an acknowledge code addressed to the sender. Broadcast packets are never acknowledged.

Accepted writes, reads and compare-and-swap (lock) requests go into a small request queue that feeds the upstream responder through a valid/ready handshake. A read or lock request needs a response, so its transaction label is marked outstanding together with the requester's ID. When the responder later reports a response for that label, the block returns the stored requester ID and frees the label. This is how each response is matched to its request.

The block never drops an addressed packet without telling the sender. A bad CRC, a full queue or a label that is already in flight each produce a busy acknowledge, so the sender knows to retry.

Top module: `rx_async_filter`

## Requirements
- R1: A header whose destination equals `node_id_i` is accepted. A header that matches neither the own ID nor a broadcast address is dropped: there is no acknowledge and nothing is queued.
- R2: A destination whose low 6 bits (node number) are 63 is a broadcast address when its upper 10 bits (bus number) equal the own bus number or are all ones. Such a packet is queued with `req_bcast_o`=1 and is never acknowledged, even when it is dropped for an error.
- R3: An acknowledge appears on `ack_valid_o` for exactly one cycle, in the cycle after the header is presented, with `ack_dest_o` equal to the header source. A queued write (tcode 0x0 or 0x1) gets code 0x1 (complete). A queued read (tcode 0x4 or 0x5) or lock (tcode 0x9) gets code 0x2 (pending).
- R4: A unicast header with the CRC-good flag low gets busy code 0x4 and is never queued.
- R5: A unicast header with any other tcode gets code 0xE (type error) and is not queued.
- R6: When the request queue is full, an addressed header gets busy code 0x4 and is not queued. The entries already in the queue are kept unchanged.
- R7: A queued unicast read or lock marks its label outstanding. A later unicast read or lock with an outstanding label gets busy code 0x4 and is not queued. Writes neither check nor mark labels.
- R8: A response pulse on `rsp_valid_i` with an outstanding label sets `rsp_hit_o` for one cycle, in the next cycle, with `rsp_dest_o` equal to the stored requester ID, and it frees the label. A response with a free label sets `rsp_miss_o` instead.
- R9: After reset, no acknowledge, request or response output is active, the queue is empty and every label is free.
- R10: Queued requests leave in arrival order. `req_valid_o` is high while the queue holds an entry, and an entry is removed on a cycle where `req_valid_o` and `req_ready_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | 16 | Own ID: bus number [15:6], node number [5:0] |
| hdr_valid_i | input | 1 | Header present this cycle |
| hdr_dest_i | input | 16 | Destination ID |
| hdr_src_i | input | 16 | Source ID |
| hdr_tcode_i | input | 4 | Transaction code |
| hdr_tlabel_i | input | 6 | Transaction label |
| hdr_crc_ok_i | input | 1 | Header CRC good |
| ack_valid_o | output | 1 | Acknowledge pulse |
| ack_code_o | output | 4 | Acknowledge code |
| ack_dest_o | output | 16 | Sender the acknowledge goes to |
| req_valid_o | output | 1 | Request queue head valid |
| req_ready_i | input | 1 | Responder takes the head |
| req_tcode_o | output | 4 | Head transaction code |
| req_tlabel_o | output | 6 | Head label |
| req_src_o | output | 16 | Head requester ID |
| req_bcast_o | output | 1 | Head arrived by broadcast |
| rsp_valid_i | input | 1 | Responder issues a response |
| rsp_tlabel_i | input | 6 | Label of that response |
| rsp_hit_o | output | 1 | Response matched an outstanding label |
| rsp_miss_o | output | 1 | Response label was not outstanding |
| rsp_dest_o | output | 16 | Requester ID for the matched response |

## Verification
The bench builds the block with a request queue of depth 2, so two unread writes are enough to reach the full state and see the busy acknowledge. The ID and label widths keep their defaults, with own ID 0x0A45. That choice makes the local broadcast 0x0A7F, the global broadcast 0xFFFF and the broadcast of a foreign bus 0x0ABF, and all three can be driven directly. It also keeps the full 64-label table in play, so freeing a label and then reusing it can be checked.

// File: rtl/rx_async_pkg.sv
package rx_async_pkg;
  localparam int TCODE_W = 4;
  localparam int ACK_W   = 4;

  localparam logic [TCODE_W-1:0] TC_WR_QUAD = 4'h0;
  localparam logic [TCODE_W-1:0] TC_WR_BLK  = 4'h1;
  localparam logic [TCODE_W-1:0] TC_RD_QUAD = 4'h4;
  localparam logic [TCODE_W-1:0] TC_RD_BLK  = 4'h5;
  localparam logic [TCODE_W-1:0] TC_LOCK    = 4'h9;

  typedef enum logic [ACK_W-1:0] {
    ACK_COMPLETE = 4'h1,
    ACK_PENDING  = 4'h2,
    ACK_BUSY     = 4'h4,
    ACK_TYPE_ERR = 4'hE
  } ack_code_e;

  function automatic logic tc_is_write(input logic [TCODE_W-1:0] tc);
    return (tc == TC_WR_QUAD) || (tc == TC_WR_BLK);
  endfunction

  function automatic logic tc_wants_rsp(input logic [TCODE_W-1:0] tc);
    return (tc == TC_RD_QUAD) || (tc == TC_RD_BLK) || (tc == TC_LOCK);
  endfunction
endpackage

// File: rtl/rx_addr_match.sv
module rx_addr_match #(
  parameter int BUS_W  = 10,
  parameter int NODE_W = 6,
  localparam int ID_W  = BUS_W + NODE_W
) (
  input  logic [ID_W-1:0] node_id_i,
  input  logic [ID_W-1:0] dest_i,
  output logic            own_o,
  output logic            bcast_o
);
  logic [NODE_W-1:0] dest_node;
  logic [BUS_W-1:0]  dest_bus;
  logic [BUS_W-1:0]  own_bus;

  assign dest_node = dest_i[NODE_W-1:0];
  assign dest_bus  = dest_i[ID_W-1:NODE_W];
  assign own_bus   = node_id_i[ID_W-1:NODE_W];

  assign own_o   = (dest_i == node_id_i);
  // all-ones node number broadcasts on own bus or on every bus
  assign bcast_o = (&dest_node) && ((dest_bus == own_bus) || (&dest_bus));
endmodule

// File: rtl/rx_req_fifo.sv
module rx_req_fifo #(
  parameter int W     = 27,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign rdata_o = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CNT_W'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= wdata_i;
  end

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/rx_label_table.sv
module rx_label_table #(
  parameter int TLABEL_W = 6,
  parameter int ID_W     = 16,
  localparam int NUM     = 1 << TLABEL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TLABEL_W-1:0] chk_label_i,
  output logic                busy_o,
  input  logic                set_i,
  input  logic [TLABEL_W-1:0] set_label_i,
  input  logic [ID_W-1:0]     set_src_i,
  input  logic                rsp_i,
  input  logic [TLABEL_W-1:0] rsp_label_i,
  output logic                hit_o,
  output logic                miss_o,
  output logic [ID_W-1:0]     dest_o
);
  logic [NUM-1:0]  busy_q;
  logic [ID_W-1:0] src_q [NUM];
  logic            hit_q, miss_q;
  logic [ID_W-1:0] dest_q;
  logic            rsp_busy;

  assign busy_o   = busy_q[chk_label_i];
  assign rsp_busy = busy_q[rsp_label_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      hit_q  <= 1'b0;
      miss_q <= 1'b0;
      dest_q <= '0;
    end else begin
      hit_q  <= rsp_i && rsp_busy;
      miss_q <= rsp_i && !rsp_busy;
      if (rsp_i && rsp_busy) begin
        busy_q[rsp_label_i] <= 1'b0;
        dest_q              <= src_q[rsp_label_i];
      end
      // a set only targets a free label, a clear only a busy one: no overlap
      if (set_i) busy_q[set_label_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (set_i) src_q[set_label_i] <= set_src_i;
  end

  assign hit_o  = hit_q;
  assign miss_o = miss_q;
  assign dest_o = dest_q;

  assert_set_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> !busy_q[set_label_i]);
  assert_rsp_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));
  assert_hit_frees_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_i && rsp_busy && !(set_i && set_label_i == rsp_label_i)) |=> !busy_q[$past(rsp_label_i)]);
endmodule

// File: rtl/rx_async_filter.sv
module rx_async_filter
  import rx_async_pkg::*;
#(
  parameter int BUS_W      = 10,
  parameter int NODE_W     = 6,
  parameter int TLABEL_W   = 6,
  parameter int FIFO_DEPTH = 4,
  localparam int ID_W      = BUS_W + NODE_W,
  localparam int ENTRY_W   = TCODE_W + TLABEL_W + ID_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ID_W-1:0]     node_id_i,
  input  logic                hdr_valid_i,
  input  logic [ID_W-1:0]     hdr_dest_i,
  input  logic [ID_W-1:0]     hdr_src_i,
  input  logic [TCODE_W-1:0]  hdr_tcode_i,
  input  logic [TLABEL_W-1:0] hdr_tlabel_i,
  input  logic                hdr_crc_ok_i,
  output logic                ack_valid_o,
  output logic [ACK_W-1:0]    ack_code_o,
  output logic [ID_W-1:0]     ack_dest_o,
  output logic                req_valid_o,
  input  logic                req_ready_i,
  output logic [TCODE_W-1:0]  req_tcode_o,
  output logic [TLABEL_W-1:0] req_tlabel_o,
  output logic [ID_W-1:0]     req_src_o,
  output logic                req_bcast_o,
  input  logic                rsp_valid_i,
  input  logic [TLABEL_W-1:0] rsp_tlabel_i,
  output logic                rsp_hit_o,
  output logic                rsp_miss_o,
  output logic [ID_W-1:0]     rsp_dest_o
);
  logic m_own, m_bc_raw, m_bc;
  logic fifo_full, fifo_empty, push, pop;
  logic lbl_busy, lbl_set;
  logic ack_set;
  ack_code_e ack_code_d, ack_code_q;
  logic ack_valid_q;
  logic [ID_W-1:0] ack_dest_q;
  logic [ENTRY_W-1:0] wentry, rentry;
  logic is_wr, wants_rsp;

  rx_addr_match #(.BUS_W(BUS_W), .NODE_W(NODE_W)) u_match (
    .node_id_i (node_id_i),
    .dest_i    (hdr_dest_i),
    .own_o     (m_own),
    .bcast_o   (m_bc_raw)
  );
  assign m_bc = m_bc_raw && !m_own;

  assign is_wr     = tc_is_write(hdr_tcode_i);
  assign wants_rsp = tc_wants_rsp(hdr_tcode_i);

  always_comb begin
    ack_set    = 1'b0;
    ack_code_d = ACK_COMPLETE;
    push       = 1'b0;
    lbl_set    = 1'b0;
    if (hdr_valid_i && (m_own || m_bc)) begin
      ack_set = m_own;
      if (!hdr_crc_ok_i) begin
        ack_code_d = ACK_BUSY;
      end else if (!is_wr && !wants_rsp) begin
        ack_code_d = ACK_TYPE_ERR;
      end else if (fifo_full) begin
        ack_code_d = ACK_BUSY;
      end else if (wants_rsp && m_own && lbl_busy) begin
        ack_code_d = ACK_BUSY;
      end else begin
        push       = 1'b1;
        ack_code_d = wants_rsp ? ACK_PENDING : ACK_COMPLETE;
        lbl_set    = wants_rsp && m_own;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_valid_q <= 1'b0;
      ack_code_q  <= ACK_COMPLETE;
      ack_dest_q  <= '0;
    end else begin
      ack_valid_q <= ack_set;
      if (ack_set) begin
        ack_code_q <= ack_code_d;
        ack_dest_q <= hdr_src_i;
      end
    end
  end

  assign ack_valid_o = ack_valid_q;
  assign ack_code_o  = ack_code_q;
  assign ack_dest_o  = ack_dest_q;

  assign wentry = {hdr_tcode_i, hdr_tlabel_i, hdr_src_i, m_bc};
  assign pop    = !fifo_empty && req_ready_i;

  rx_req_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (wentry),
    .pop_i   (pop),
    .rdata_o (rentry),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  assign req_valid_o = !fifo_empty;
  assign {req_tcode_o, req_tlabel_o, req_src_o, req_bcast_o} = rentry;

  rx_label_table #(.TLABEL_W(TLABEL_W), .ID_W(ID_W)) u_labels (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chk_label_i (hdr_tlabel_i),
    .busy_o      (lbl_busy),
    .set_i       (lbl_set),
    .set_label_i (hdr_tlabel_i),
    .set_src_i   (hdr_src_i),
    .rsp_i       (rsp_valid_i),
    .rsp_label_i (rsp_tlabel_i),
    .hit_o       (rsp_hit_o),
    .miss_o      (rsp_miss_o),
    .dest_o      (rsp_dest_o)
  );

  assert_miss_no_ack_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && !m_own && !m_bc_raw) |=> !ack_valid_o);
  assert_bcast_silent_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && m_bc) |=> !ack_valid_o);
  assert_ack_dest_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> (ack_dest_o == $past(hdr_src_i)));
  assert_crc_no_push_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_valid_i && !hdr_crc_ok_i) |-> !push);
  assert_push_needs_hdr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |-> hdr_valid_i);
endmodule

// File: tb/rx_async_filter_bench.sv
module rx_async_filter_bench;
  localparam logic [15:0] NODE = 16'h0A45;
  localparam int NV = 13;
  // {dest, src, tcode, label, crc_ok, exp_ack, exp_code, exp_push}
  localparam logic [48:0] VEC [NV] = '{
    {16'h0A45, 16'h1001, 4'h0, 6'd1,  1'b1, 1'b1, 4'h1, 1'b1},  // R1 R3 write
    {16'h0A45, 16'h1002, 4'h4, 6'd2,  1'b1, 1'b1, 4'h2, 1'b1},  // R3 R7 read
    {16'h0A45, 16'h1003, 4'h9, 6'd3,  1'b1, 1'b1, 4'h2, 1'b1},  // R3 lock
    {16'h0A46, 16'h1004, 4'h0, 6'd4,  1'b1, 1'b0, 4'h0, 1'b0},  // R1 other node
    {16'h0A7F, 16'h1005, 4'h1, 6'd5,  1'b1, 1'b0, 4'h0, 1'b1},  // R2 local bcast
    {16'hFFFF, 16'h1006, 4'h0, 6'd6,  1'b1, 1'b0, 4'h0, 1'b1},  // R2 global bcast
    {16'h0ABF, 16'h1007, 4'h0, 6'd7,  1'b1, 1'b0, 4'h0, 1'b0},  // R2 foreign bus
    {16'h0A45, 16'h1008, 4'h0, 6'd8,  1'b0, 1'b1, 4'h4, 1'b0},  // R4 crc
    {16'h0A45, 16'h1009, 4'h7, 6'd9,  1'b1, 1'b1, 4'hE, 1'b0},  // R5 tcode
    {16'h0A7F, 16'h100A, 4'h0, 6'd11, 1'b0, 1'b0, 4'h0, 1'b0},  // R2 R4 bcast crc
    {16'h0A45, 16'h100B, 4'h5, 6'd2,  1'b1, 1'b1, 4'h4, 1'b0},  // R7 dup label
    {16'h0A45, 16'h100C, 4'h1, 6'd2,  1'b1, 1'b1, 4'h1, 1'b1},  // R7 write ignores
    {16'h0A45, 16'h100D, 4'h5, 6'd10, 1'b1, 1'b1, 4'h2, 1'b1}   // R3 block read
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic hdr_valid = 0, hdr_crc = 0, req_ready = 0, rsp_valid = 0;
  logic [15:0] hdr_dest = '0, hdr_src = '0;
  logic [3:0]  hdr_tcode = '0;
  logic [5:0]  hdr_lbl = '0, rsp_lbl = '0;
  logic ack_valid, req_valid, req_bcast, rsp_hit, rsp_miss;
  logic [3:0] ack_code, req_tcode;
  logic [15:0] ack_dest, req_src, rsp_dest;
  logic [5:0] req_lbl;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rx_async_filter #(.FIFO_DEPTH(2)) u_rx_async_filter (
    .clk_i(clk), .rst_ni(rst_n), .node_id_i(NODE),
    .hdr_valid_i(hdr_valid), .hdr_dest_i(hdr_dest), .hdr_src_i(hdr_src),
    .hdr_tcode_i(hdr_tcode), .hdr_tlabel_i(hdr_lbl), .hdr_crc_ok_i(hdr_crc),
    .ack_valid_o(ack_valid), .ack_code_o(ack_code), .ack_dest_o(ack_dest),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_tcode_o(req_tcode),
    .req_tlabel_o(req_lbl), .req_src_o(req_src), .req_bcast_o(req_bcast),
    .rsp_valid_i(rsp_valid), .rsp_tlabel_i(rsp_lbl),
    .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss), .rsp_dest_o(rsp_dest)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] d, input logic [15:0] s, input logic [3:0] tc,
                      input logic [5:0] l, input logic crc);
    @(negedge clk);
    hdr_valid = 1; hdr_dest = d; hdr_src = s; hdr_tcode = tc; hdr_lbl = l; hdr_crc = crc;
    @(negedge clk);
    hdr_valid = 0;
  endtask

  task automatic pop();
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
  endtask

  task automatic rsp(input logic [5:0] l);
    @(negedge clk);
    rsp_valid = 1; rsp_lbl = l;
    @(negedge clk);
    rsp_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 ack_valid", ack_valid, 0);
    chk("R9 req_valid", req_valid, 0);
    chk("R9 rsp_hit", rsp_hit, 0);
    chk("R9 rsp_miss", rsp_miss, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [48:0] v;
      v = VEC[i];
      send(v[48:33], v[32:17], v[16:13], v[12:7], v[6]);
      chk($sformatf("R3 ack_valid v%0d", i), ack_valid, v[5]);
      if (v[5]) begin
        chk($sformatf("R3 ack_code v%0d", i), ack_code, v[4:1]);
        chk($sformatf("R3 ack_dest v%0d", i), ack_dest, v[32:17]);
      end
      chk($sformatf("R1 queued v%0d", i), req_valid, v[0]);
      if (v[0]) begin
        chk($sformatf("R10 tcode v%0d", i), req_tcode, v[16:13]);
        chk($sformatf("R10 label v%0d", i), req_lbl, v[12:7]);
        chk($sformatf("R10 src v%0d", i), req_src, v[32:17]);
        chk($sformatf("R2 bcast v%0d", i), req_bcast, v[48:33] != NODE);
        pop();
        chk($sformatf("R10 drained v%0d", i), req_valid, 0);
      end
    end

    // R6 full queue
    send(NODE, 16'h2001, 4'h0, 6'd20, 1);
    chk("R6 ack1", ack_code, 4'h1);
    send(NODE, 16'h2002, 4'h1, 6'd21, 1);
    chk("R6 ack2", ack_code, 4'h1);
    send(NODE, 16'h2003, 4'h0, 6'd22, 1);
    chk("R6 busy valid", ack_valid, 1);
    chk("R6 busy code", ack_code, 4'h4);
    chk("R6 head kept", req_lbl, 6'd20);
    pop();
    chk("R10 order second", req_lbl, 6'd21);
    chk("R6 second src", req_src, 16'h2002);
    pop();
    chk("R6 no third", req_valid, 0);

    // R8 response matching
    rsp(6'd2);
    chk("R8 hit lbl2", rsp_hit, 1);
    chk("R8 miss lbl2", rsp_miss, 0);
    chk("R8 dest lbl2", rsp_dest, 16'h1002);
    rsp(6'd2);
    chk("R8 freed lbl2 miss", rsp_miss, 1);
    chk("R8 freed lbl2 hit", rsp_hit, 0);
    rsp(6'd1);
    chk("R8 write label untracked", rsp_miss, 1);
    rsp(6'd3);
    chk("R8 hit lbl3", rsp_hit, 1);
    chk("R8 dest lbl3", rsp_dest, 16'h1003);
    rsp(6'd10);
    chk("R8 dest lbl10", rsp_dest, 16'h100D);
    @(negedge clk);
    chk("R8 hit one cycle", rsp_hit, 0);

    // R7 label reusable after response
    send(NODE, 16'h3001, 4'h4, 6'd2, 1);
    chk("R7 reuse ack", ack_code, 4'h2);
    chk("R7 reuse queued", req_valid, 1);
    pop();
    @(negedge clk);
    chk("R3 ack one cycle", ack_valid, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule